// File: doc/BRIEF.md
# MSI Interrupt Destination Router

This block sits where message-signalled interrupt writes reach the processor side of a system. Each cycle it may receive one memory write made of a 32-bit address and a 32-bit data word. It first checks whether the address falls inside the interrupt window. If it does, it pulls the destination, the redirection hint and the destination-mode bit out of the address. It then works out which of `NUM_CPU` processor interrupt controllers take the message. The result is a registered one-bit-per-processor accept vector, a delivery strobe, and the interrupt vector taken from the data word.

Each processor has a physical ID and a flat-mode logical ID, supplied as inputs. The destination-mode bit always picks how the receivers match. With physical mode, a receiver accepts on an exact ID match. With logical mode, a receiver accepts when its logical ID overlaps the destination. The redirection hint matters only together with logical mode. In that case the set of matching processors is narrowed to the single one with the lowest priority, where each processor's priority comes from a 4-bit input.

Top module: `msi_irq_router`

## Requirements
- R1: A write is treated as an interrupt only when address bits 31:20 equal 0xFEE. Any other write leaves `accept` all zero and `deliver_valid` low.
- R2: With address bit 2 (destination mode) = 0 and address bit 3 (redirection hint) = 0, processor i accepts exactly when address bits 19:12 equal its physical ID.
- R3: With destination mode = 1 and hint = 0, processor i accepts when its logical ID shares any set bit with address bits 19:12. Several processors may accept the same write.
- R4: With hint = 1 and destination mode = 1, exactly one processor accepts: the processor with the lowest 4-bit priority among those that match by the logical rule of R3.
- R5: When several matching processors share the lowest priority under R4, the one with the lowest index accepts.
- R6: With hint = 1 and destination mode = 0, the result is the same as the physical match of R2.
- R7: Address bits 11:4 and bits 1:0 have no effect on the result.
- R8: On a delivery, `deliver_vector` shows data bits 7:0. When there is no delivery, it keeps its previous value.
- R9: `accept` and `deliver_valid` appear one clock after the write is sampled. Both are zero/low in any cycle that follows a cycle with no write.
- R10: A write inside the window that no processor matches produces no delivery pulse.
- R11: After reset, `accept`, `deliver_valid` and `deliver_vector` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A memory write is presented this cycle |
| wr_addr | input | 32 | Write address |
| wr_data | input | 32 | Write data |
| phys_ids | input | NUM_CPU*8 | Physical ID of processor i in bits [8i+7:8i] |
| logic_ids | input | NUM_CPU*8 | Flat logical ID of processor i in bits [8i+7:8i] |
| cpu_prio | input | NUM_CPU*4 | Priority of processor i in bits [4i+3:4i]; lower wins |
| accept | output | NUM_CPU | Registered per-processor accept vector |
| deliver_valid | output | 1 | One-cycle delivery strobe |
| deliver_vector | output | 8 | Interrupt vector of the last delivery |

## Verification
Every result is due exactly one rising edge after the write is sampled. The bench drives a write on a falling edge and samples `accept`, `deliver_valid` and `deliver_vector` on the next falling edge, after that single register stage. It then drops the write and checks one falling edge later that the strobe and accept vector have returned to zero. The vector-hold behaviour is checked against the value from the last delivery seen by the bench, after writes that are either outside the window or match no processor.

// File: rtl/msi_router_pkg.sv
package msi_router_pkg;

    localparam int          ADDR_W     = 32;
    localparam int          DEST_W     = 8;
    localparam logic [11:0] WINDOW_TAG = 12'hFEE;
    localparam int          TAG_LSB    = 20;
    localparam int          DEST_LSB   = 12;
    localparam int          HINT_BIT   = 3;
    localparam int          MODE_BIT   = 2;

    typedef struct packed {
        logic              hit;
        logic [DEST_W-1:0] dest;
        logic              hint;
        logic              logical;
    } msi_fields_t;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_router_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output msi_fields_t       fields
);
    always_comb begin
        fields.hit     = (addr[ADDR_W-1:TAG_LSB] == WINDOW_TAG);
        fields.dest    = addr[DEST_LSB +: DEST_W];
        fields.hint    = addr[HINT_BIT];
        fields.logical = addr[MODE_BIT];
    end
endmodule

// File: rtl/msi_dest_match.sv
module msi_dest_match #(
    parameter int NUM_CPU = 4,
    parameter int ID_W    = 8
) (
    input  logic [ID_W-1:0]         dest,
    input  logic                    logical,
    input  logic [NUM_CPU*ID_W-1:0] phys_ids,
    input  logic [NUM_CPU*ID_W-1:0] logic_ids,
    output logic [NUM_CPU-1:0]      hit_mask
);
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        logic phys_eq;
        logic log_any;
        assign phys_eq     = (phys_ids[i*ID_W +: ID_W] == dest);
        assign log_any     = |(logic_ids[i*ID_W +: ID_W] & dest);
        assign hit_mask[i] = logical ? log_any : phys_eq;
    end
endmodule

// File: rtl/msi_lowest_prio_pick.sv
module msi_lowest_prio_pick #(
    parameter int NUM_CPU = 4,
    parameter int PRIO_W  = 4
) (
    input  logic [NUM_CPU-1:0]        cand,
    input  logic [NUM_CPU*PRIO_W-1:0] prio,
    output logic [NUM_CPU-1:0]        winner
);
    logic [PRIO_W-1:0] best_prio;
    logic              found;

    always_comb begin
        winner    = '0;
        best_prio = '0;
        found     = 1'b0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                winner    = '0;
                winner[i] = 1'b1;
                best_prio = prio[i*PRIO_W +: PRIO_W];
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_irq_router.sv
module msi_irq_router
    import msi_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ID_W    = 8,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [NUM_CPU*ID_W-1:0]   phys_ids,
    input  logic [NUM_CPU*ID_W-1:0]   logic_ids,
    input  logic [NUM_CPU*PRIO_W-1:0] cpu_prio,
    output logic [NUM_CPU-1:0]        accept,
    output logic                      deliver_valid,
    output logic [VEC_W-1:0]          deliver_vector
);
    typedef struct packed {
        logic [NUM_CPU-1:0] accept;
        logic               valid;
        logic [VEC_W-1:0]   vector;
    } out_state_t;

    msi_fields_t        fields;
    logic [NUM_CPU-1:0] hit_mask;
    logic [NUM_CPU-1:0] narrowed;
    out_state_t         st_d;
    out_state_t         st_q;

    msi_addr_decode u_decode (
        .addr   (wr_addr),
        .fields (fields)
    );

    msi_dest_match #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_match (
        .dest      (fields.dest),
        .logical   (fields.logical),
        .phys_ids  (phys_ids),
        .logic_ids (logic_ids),
        .hit_mask  (hit_mask)
    );

    msi_lowest_prio_pick #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) u_pick (
        .cand   (hit_mask),
        .prio   (cpu_prio),
        .winner (narrowed)
    );

    always_comb begin
        logic [NUM_CPU-1:0] final_mask;
        final_mask = (fields.hint && fields.logical) ? narrowed : hit_mask;
        st_d        = st_q;
        st_d.accept = '0;
        st_d.valid  = 1'b0;
        if (wr_valid && fields.hit) begin
            st_d.accept = final_mask;
            st_d.valid  = |final_mask;
            if (|final_mask) begin
                st_d.vector = wr_data[VEC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept         = st_q.accept;
    assign deliver_valid  = st_q.valid;
    assign deliver_vector = st_q.vector;
endmodule

// File: rtl/msi_irq_router_chk.sv
module msi_irq_router_chk #(
    parameter int NUM_CPU = 4,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input logic [31:0]        wr_addr,
    input logic [NUM_CPU-1:0] accept,
    input logic               deliver_valid,
    input logic [VEC_W-1:0]   deliver_vector
);
    assert_outside_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr[31:20] != 12'hFEE) |=> (!deliver_valid && accept == '0));

    assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr[31:20] == 12'hFEE && wr_addr[3] && wr_addr[2]) |=> $onehot0(accept));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!deliver_valid && accept == '0));

    assert_accept_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept != '0) |-> deliver_valid);

    assert_vector_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver_valid |-> $stable(deliver_vector) || $past(!rst_n));
endmodule

bind msi_irq_router msi_irq_router_chk #(.NUM_CPU(NUM_CPU), .VEC_W(VEC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .wr_addr        (wr_addr),
    .accept         (accept),
    .deliver_valid  (deliver_valid),
    .deliver_vector (deliver_vector)
);

// File: tb/tb_msi_irq_router.sv
`timescale 1ns/1ps
module tb_msi_irq_router;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [31:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [N*8-1:0] phys_ids;
    logic [N*8-1:0] logic_ids;
    logic [N*4-1:0] cpu_prio;
    logic [N-1:0]  accept;
    logic          deliver_valid;
    logic [7:0]    deliver_vector;

    int errors = 0;
    int checks = 0;
    logic [7:0] last_vec = 8'h00;

    always #5 clk = ~clk;

    msi_irq_router dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .phys_ids(phys_ids), .logic_ids(logic_ids),
        .cpu_prio(cpu_prio), .accept(accept), .deliver_valid(deliver_valid),
        .deliver_vector(deliver_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write, sample one edge later, then confirm the idle cycle.
    task automatic send(input string req, input logic [31:0] a, input logic [31:0] d,
                        input logic [N-1:0] exp_acc);
        logic exp_v;
        exp_v = |exp_acc;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        if (exp_v) last_vec = d[7:0];
        check({req, " accept"}, 32'(accept), 32'(exp_acc));
        check({req, " valid"}, 32'(deliver_valid), 32'(exp_v));
        check({req, " vector"}, 32'(deliver_vector), 32'(last_vec));
        @(negedge clk);
        check("R9 idle valid", 32'(deliver_valid), 32'd0);
        check("R9 idle accept", 32'(accept), 32'd0);
    endtask

    task automatic t_reset;
        check("R11 accept", 32'(accept), 32'd0);
        check("R11 valid", 32'(deliver_valid), 32'd0);
        check("R11 vector", 32'(deliver_vector), 32'd0);
    endtask

    task automatic t_physical;
        send("R2 phys dest 0x12", 32'hFEE1_2000, 32'h41, 4'b0100);
        send("R2 phys dest 0x13", 32'hFEE1_3000, 32'h52, 4'b1000);
        send("R6 hint phys dest 0x10", 32'hFEE1_0008, 32'h63, 4'b0001);
    endtask

    task automatic t_logical;
        send("R3 logical 0x05", 32'hFEE0_5004, 32'h74, 4'b0101);
        send("R3 logical 0x0F", 32'hFEE0_F004, 32'h75, 4'b1111);
        send("R7 reserved bits", 32'hFEE0_AFF7, 32'h76, 4'b1010);
    endtask

    task automatic t_lowest;
        cpu_prio = {4'd2, 4'd1, 4'd3, 4'd5};
        send("R4 lowest of all", 32'hFEE0_F00C, 32'h81, 4'b0100);
        send("R4 lowest of 0,1,3", 32'hFEE0_B00C, 32'h82, 4'b1000);
        cpu_prio = {4'd7, 4'd7, 4'd7, 4'd7};
        send("R5 tie 2,3", 32'hFEE0_C00C, 32'h83, 4'b0100);
        send("R5 tie all", 32'hFEE0_F00F, 32'h84, 4'b0001);
    endtask

    task automatic t_rejects;
        send("R1 outside window", 32'hFED0_1004, 32'h99, 4'b0000);
        send("R1 near window", 32'hFEF0_1004, 32'h9A, 4'b0000);
        send("R10 no phys match", 32'hFEE7_7000, 32'h9B, 4'b0000);
        send("R10 no logical match", 32'hFEE3_0004, 32'h9C, 4'b0000);
        send("R8 vector after rejects", 32'hFEE0_1004, 32'hA5, 4'b0001);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            phys_ids[i*8 +: 8]  = 8'h10 + 8'(i);
            logic_ids[i*8 +: 8] = 8'(1 << i);
        end
        cpu_prio = '0;
        #1;
        t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_physical;
        t_logical;
        t_lowest;
        t_rejects;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule